// File: doc/BRIEF.md
# Addressable Bit Latch with Decoder Mode

This block keeps a small bank of single-bit storage cells and writes them one at a time. A binary select picks one cell and a serial data bit supplies its value, so a stream of (select, data) pairs builds a parallel word. Two active-low controls choose what happens on each rising clock edge. The bank can be written, held, cleared, or used as an active-high one-hot decoder / demultiplexer. All outputs come straight from registers.

It is the synchronous equivalent of a level-sensitive addressable latch. Every control, select and data input is sampled on the rising edge of `clk`. The result appears on `q` after that edge, one cycle later. A synchronous active-low reset empties the bank.

Top module: `bitsel_latch`

## Requirements
- R1: While `rst_n` is low at a rising edge, every bit of `q` is 0 after that edge.
- R2: Write mode is `wr_en_n`=0 and `clr_n`=1. In this mode, bit `q[sel]` takes the value of `din` at the edge.
- R3: In write mode, every bit other than `q[sel]` keeps its previous value. Back-to-back writes to different selects therefore accumulate.
- R4: Hold mode is `wr_en_n`=1 and `clr_n`=1. In this mode, all bits of `q` keep their values whatever `sel` and `din` are.
- R5: Decode mode is `wr_en_n`=0 and `clr_n`=0. In this mode, `q[sel]` takes `din` and every other bit becomes 0.
- R6: In decode mode with `din`=1, `q` is exactly one-hot, with the single 1 at bit position `sel`.
- R7: Clear mode is `wr_en_n`=1 and `clr_n`=0. In this mode, all bits become 0 whatever `sel` and `din` are.
- R8: `sel` is an unsigned binary index with bit 0 as its least significant bit. A value of 0 addresses `q[0]` and a value of 7 addresses `q[7]`.
- R9: After leaving decode mode, the register holds exactly the word shown during decode. A following hold keeps that word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en_n | input | 1 | Active-low write/decode enable |
| clr_n | input | 1 | Active-low clear; combined with `wr_en_n` it selects decode |
| sel | input | 3 | Binary index of the addressed bit |
| din | input | 1 | Data bit for the addressed position |
| q | output | 8 | Registered stored bits |

## Verification
The assertions assume that `wr_en_n`, `clr_n`, `sel` and `din` are known (not X) at each sampled edge once reset has been released. They also assume that the mode seen at an edge determines the word after that edge. The stimulus changes every input just after a rising edge, so each value stays stable across the following edge. Select changes are therefore never seen part-way through a write. The random sequence draws modes and selects independently, but always moves them together at this same safe point.

// File: rtl/lat_pkg.sv
// Shared types for the addressable bit latch.
// Assumes nothing beyond a two-bit mode encoding.
package lat_pkg;
    typedef enum logic [1:0] {
        MODE_WRITE = 2'd0,
        MODE_HOLD  = 2'd1,
        MODE_DEMUX = 2'd2,
        MODE_CLEAR = 2'd3
    } lat_mode_e;
endpackage

// File: rtl/lat_mode_dec.sv
// Maps the two active-low controls onto one of four operating modes.
// Assumes both controls are sampled by the caller on the same clock edge.
module lat_mode_dec
    import lat_pkg::*;
(
    input  logic      wr_en_n,
    input  logic      clr_n,
    output lat_mode_e mode
);
    // Purpose: decode the control pair into a mode.
    always_comb begin
        case ({wr_en_n, clr_n})
            2'b01:   mode = MODE_WRITE;
            2'b11:   mode = MODE_HOLD;
            2'b00:   mode = MODE_DEMUX;
            default: mode = MODE_CLEAR;
        endcase
    end
endmodule

// File: rtl/lat_sel_dec.sv
// Converts a binary index into a one-hot hit vector, bit 0 for index 0.
// Assumes WIDTH does not exceed 2**ADDR_W.
module lat_sel_dec #(
    parameter int WIDTH  = 8,
    parameter int ADDR_W = $clog2(WIDTH)
) (
    input  logic [ADDR_W-1:0] sel,
    output logic [WIDTH-1:0]  hit
);
    // Purpose: one comparator per bit position.
    for (genvar i = 0; i < WIDTH; i++) begin : g_hit
        assign hit[i] = (sel == ADDR_W'(i));
    end
endmodule

// File: rtl/lat_bit_cell.sv
// One storage bit: chooses its next value from the mode and its hit line.
// Assumes hit is high for at most one cell of the bank.
module lat_bit_cell
    import lat_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  lat_mode_e mode,
    input  logic      hit,
    input  logic      din,
    output logic      q
);
    logic nxt;

    // Purpose: next-state selection per mode.
    always_comb begin
        case (mode)
            MODE_WRITE: nxt = hit ? din : q;
            MODE_HOLD:  nxt = q;
            MODE_DEMUX: nxt = hit & din;
            default:    nxt = 1'b0;
        endcase
    end

    // Purpose: state register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= 1'b0;
        else        q <= nxt;
    end
endmodule

// File: rtl/bitsel_latch.sv
// Addressable bit latch: write, hold, one-hot decode and clear modes,
// all applied on the rising clock edge, with registered outputs.
// Assumes controls, index and data are stable around each rising edge.
module bitsel_latch
    import lat_pkg::*;
#(
    parameter int WIDTH  = 8,
    parameter int ADDR_W = $clog2(WIDTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_n,
    input  logic              clr_n,
    input  logic [ADDR_W-1:0] sel,
    input  logic              din,
    output logic [WIDTH-1:0]  q
);
    lat_mode_e         mode;
    logic [WIDTH-1:0]  hit;

    lat_mode_dec u_mode (.wr_en_n(wr_en_n), .clr_n(clr_n), .mode(mode));

    lat_sel_dec #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_sel (.sel(sel), .hit(hit));

    // Purpose: one storage cell per output bit.
    for (genvar i = 0; i < WIDTH; i++) begin : g_cell
        lat_bit_cell u_cell (
            .clk  (clk),
            .rst_n(rst_n),
            .mode (mode),
            .hit  (hit[i]),
            .din  (din),
            .q    (q[i])
        );
    end

    // Assertions on port behaviour across one edge.
    a_r2_write_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en_n && clr_n) |=> (q[$past(sel)] == $past(din)));
    a_r3_write_others: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en_n && clr_n) |=> ($countones(q ^ $past(q)) <= 1));
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_n && clr_n) |=> (q == $past(q)));
    a_r5_demux: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en_n && !clr_n) |=> ($onehot0(q) && q[$past(sel)] == $past(din)));
    a_r6_decode: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en_n && !clr_n && din) |=> $onehot(q));
    a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_n && !clr_n) |=> (q == '0));
endmodule

// File: tb/bitsel_latch_test.sv
`timescale 1ns/1ps
module bitsel_latch_test;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       wr_en_n;
    logic       clr_n;
    logic [2:0] sel;
    logic       din;
    logic [7:0] q;
    logic [7:0] expq;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    bitsel_latch uut (.clk(clk), .rst_n(rst_n), .wr_en_n(wr_en_n), .clr_n(clr_n),
                      .sel(sel), .din(din), .q(q));

    task automatic check(input string req, input logic [7:0] exp_v);
        checks++;
        if (q !== exp_v) begin
            errors++;
            $display("FAIL %s: q=%b expected %b", req, q, exp_v);
        end
    endtask

    // One clocked operation: drive, update model, sample after edge.
    task automatic step(input logic e, input logic c, input logic [2:0] a,
                        input logic d, input string req);
        wr_en_n = e; clr_n = c; sel = a; din = d;
        @(posedge clk);
        case ({e, c})
            2'b01: expq[a] = d;
            2'b11: ;
            2'b00: begin expq = 8'h00; expq[a] = d; end
            default: expq = 8'h00;
        endcase
        #1;
        check(req, expq);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; wr_en_n = 1'b0; clr_n = 1'b1; sel = 3'd5; din = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        expq = 8'h00;
        check("R1 reset", 8'h00);
        rst_n = 1'b1;
    endtask

    task automatic t_write_walk();
        step(1'b0, 1'b1, 3'd0, 1'b1, "R8 sel0->q0");
        step(1'b1, 1'b0, 3'd0, 1'b0, "R7 clear");
        step(1'b0, 1'b1, 3'd7, 1'b1, "R8 sel7->q7");
        for (int i = 0; i < 8; i++) step(1'b0, 1'b1, 3'(i), 1'b1, "R2 write walk");
        step(1'b0, 1'b1, 3'd3, 1'b0, "R2 write zero");
    endtask

    task automatic t_retain();
        step(1'b1, 1'b0, 3'd2, 1'b1, "R7 clear between writes");
        step(1'b0, 1'b1, 3'd1, 1'b1, "R3 back-to-back a");
        step(1'b0, 1'b1, 3'd6, 1'b1, "R3 back-to-back b");
        step(1'b0, 1'b1, 3'd4, 1'b0, "R3 others kept");
        check("R3 word 0x42", 8'h42);
    endtask

    task automatic t_hold();
        for (int i = 0; i < 8; i++) step(1'b1, 1'b1, 3'(i), i[0], "R4 hold");
        check("R4 still 0x42", 8'h42);
    endtask

    task automatic t_demux();
        step(1'b0, 1'b0, 3'd5, 1'b0, "R5 demux din0");
        check("R5 all zero", 8'h00);
        step(1'b0, 1'b1, 3'd0, 1'b1, "R2 refill");
        step(1'b0, 1'b0, 3'd2, 1'b1, "R5 demux din1");
    endtask

    task automatic t_decoder();
        for (int i = 0; i < 8; i++) begin
            step(1'b0, 1'b0, 3'(i), 1'b1, "R6 decode");
            check("R6 onehot", 8'(1 << i));
        end
    endtask

    task automatic t_demux_then_hold();
        step(1'b0, 1'b0, 3'd3, 1'b1, "R5 demux");
        step(1'b1, 1'b1, 3'd6, 1'b1, "R9 hold after demux");
        check("R9 word 0x08", 8'h08);
        step(1'b0, 1'b1, 3'd1, 1'b1, "R9 write after demux");
        check("R9 word 0x0A", 8'h0A);
    endtask

    task automatic t_clear();
        step(1'b0, 1'b1, 3'd5, 1'b1, "R2 prefill");
        step(1'b1, 1'b0, 3'd5, 1'b1, "R7 clear ignores sel/din");
        check("R7 zero", 8'h00);
    endtask

    task automatic t_random();
        for (int i = 0; i < 400; i++) begin
            logic [31:0] r;
            r = $urandom;
            step(r[0], r[1] | r[5], r[4:2], r[6], "R2-mix random");
        end
    endtask

    initial begin
        t_reset();
        t_write_walk();
        t_retain();
        t_hold();
        t_demux();
        t_decoder();
        t_demux_then_hold();
        t_clear();
        t_random();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: run incomplete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule